// File: doc/BRIEF.md
# Transport stream energy-dispersal descrambler

This block sits after the Reed-Solomon decoder of a cable receiver and undoes the energy-dispersal randomisation applied to each 188-byte transport packet at the transmitter. Bytes arrive one per cycle when `in_valid` is high. `in_sop` marks the sync byte that opens each packet. `in_uncor` carries the decoder's "could not correct" verdict for the packet. A 15-stage pseudo-random generator produces eight mask bits per byte. It restarts from a fixed seed whenever a packet opens with the inverted sync value 0xB8, which happens once in every group of eight packets.

On the output side the block delivers the cleaned byte with a data enable, a one-byte sync pulse and a per-packet error flag. The inverted sync is restored to its plain value, and the transport error indicator bit is set for packets the decoder gave up on. A bypass input turns off the mask so that raw bytes pass through. The generator stays aligned while bypass is active, so descrambling can resume cleanly.

Top module: `ts_descrambler`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_en`, `out_sync` and `out_err` are 0.
- R2: Every output appears exactly one clock after its input byte: `out_en` equals `in_valid` delayed by one cycle, and `out_data` is 0 when `out_en` is 0.
- R3: A packet-start byte equal to 0xB8 loads the generator with the seed (stage 1 to stage 15 = 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0) and is output as 0x47. The generator does not advance on that byte.
- R4: Every non-start byte is XORed with the next 8 generator bits, the first bit going to bit 7. Each generator bit is stage 14 XOR stage 15 (polynomial 1 + x^14 + x^15) and is shifted into stage 1. The first data byte after a 0xB8 start is therefore XORed with 0x03.
- R5: A packet-start byte other than 0xB8 is output unchanged, and the generator advances 8 bits during it without applying them.
- R6: Cycles with `in_valid` low produce no output and do not advance the generator.
- R7: With `bypass` high, every byte, including a 0xB8 start byte, is output unchanged, while the generator keeps loading and advancing exactly as in R3 to R5.
- R8: `in_uncor` is sampled on the packet-start byte, and `out_err` is high on every output byte of that packet when it was set.
- R9: For a packet marked uncorrectable, bit 7 of the byte following the start byte is forced to 1 after any descrambling or bypass.
- R10: `out_sync` is high exactly on the output of each packet-start byte and low on all other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is the packet start (sync) byte |
| in_data | input | 8 | Input byte from the error decoder |
| in_uncor | input | 1 | Packet could not be corrected, sampled at packet start |
| bypass | input | 1 | Pass bytes without removing the scrambling mask |
| out_data | output | 8 | Descrambled byte |
| out_en | output | 1 | Output byte present |
| out_sync | output | 1 | Output byte is a packet start byte |
| out_err | output | 1 | Output byte belongs to an uncorrectable packet |

## Verification
The properties assume that `in_sop` is only raised together with `in_valid`, and that the byte after a start byte is the flagged slot only when it follows with no idle cycle in between. The checks on the sync byte and on bypass rely on `bypass` being steady across a byte's one-cycle pass. The stimulus sends whole packets of exactly 188 valid bytes and inserts idle cycles only between valid bytes. It changes `bypass` and `in_uncor` only at packet starts, and it opens every eighth packet with 0xB8.

// File: rtl/ts_dsc_pkg.sv
package ts_dsc_pkg;

    localparam int BYTE_W = 8;
    localparam int PRBS_W = 15;

    localparam logic [BYTE_W-1:0] SYNC_PLAIN = 8'h47;
    localparam logic [BYTE_W-1:0] SYNC_INV   = 8'hB8;

    // state bit k holds stage k+1; stages 1..15 = 100101010000000
    localparam logic [PRBS_W-1:0] PRBS_SEED = 15'h00A9;

    typedef enum logic [1:0] {
        KIND_DATA     = 2'd0,
        KIND_SYNC     = 2'd1,
        KIND_INV_SYNC = 2'd2
    } byte_kind_e;

    typedef struct packed {
        logic              valid;
        byte_kind_e        kind;
        logic              flag_slot;
        logic              pkt_err;
        logic [BYTE_W-1:0] data;
    } byte_ctx_t;

    // feedback bit: stage 14 xor stage 15
    function automatic logic prbs_tap(input logic [PRBS_W-1:0] st);
        return st[PRBS_W-1] ^ st[PRBS_W-2];
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_shift(input logic [PRBS_W-1:0] st);
        return {st[PRBS_W-2:0], prbs_tap(st)};
    endfunction

endpackage

// File: rtl/ts_pkt_tracker.sv
module ts_pkt_tracker
    import ts_dsc_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_uncor,
    output byte_ctx_t         ctx
);
    localparam int POS_W = $clog2(PKT_LEN + 1);
    localparam logic [POS_W-1:0] POS_MAX  = POS_W'(PKT_LEN);
    localparam logic [POS_W-1:0] POS_NEXT = POS_W'(1);

    logic [POS_W-1:0] pos_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_MAX;
            err_q <= 1'b0;
        end else if (in_valid) begin
            if (in_sop) begin
                pos_q <= POS_NEXT;
                err_q <= in_uncor;
            end else if (pos_q < POS_MAX) begin
                pos_q <= pos_q + POS_W'(1);
            end
        end
    end

    always_comb begin
        ctx.valid = in_valid;
        ctx.data  = in_data;
        if (in_sop) begin
            ctx.kind      = (in_data == SYNC_INV) ? KIND_INV_SYNC : KIND_SYNC;
            ctx.flag_slot = 1'b0;
            ctx.pkt_err   = in_uncor;
        end else begin
            ctx.kind      = KIND_DATA;
            ctx.flag_slot = (pos_q == POS_NEXT);
            ctx.pkt_err   = err_q;
        end
    end

endmodule

// File: rtl/ts_prbs_gen.sv
module ts_prbs_gen
    import ts_dsc_pkg::*;
#(
    parameter int STEPS = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             advance,
    output logic [STEPS-1:0] mask
);
    logic [PRBS_W-1:0] state_q;
    logic [PRBS_W-1:0] chain [0:STEPS];

    assign chain[0] = state_q;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign mask[STEPS-1-i] = prbs_tap(chain[i]);
        assign chain[i+1]      = prbs_shift(chain[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PRBS_SEED;
        end else if (reload) begin
            state_q <= PRBS_SEED;
        end else if (advance) begin
            state_q <= chain[STEPS];
        end
    end

endmodule

// File: rtl/ts_byte_mod.sv
module ts_byte_mod
    import ts_dsc_pkg::*;
(
    input  byte_ctx_t         ctx,
    input  logic [BYTE_W-1:0] mask,
    input  logic              bypass,
    output logic [BYTE_W-1:0] result
);
    logic [BYTE_W-1:0] cleaned;

    always_comb begin
        unique case (ctx.kind)
            KIND_INV_SYNC: cleaned = bypass ? ctx.data : SYNC_PLAIN;
            KIND_SYNC:     cleaned = ctx.data;
            default:       cleaned = bypass ? ctx.data : (ctx.data ^ mask);
        endcase
        result = cleaned;
        if (ctx.flag_slot && ctx.pkt_err) begin
            result[BYTE_W-1] = 1'b1;
        end
    end

endmodule

// File: rtl/ts_descrambler.sv
module ts_descrambler
    import ts_dsc_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    input  logic       in_uncor,
    input  logic       bypass,
    output logic [7:0] out_data,
    output logic       out_en,
    output logic       out_sync,
    output logic       out_err
);
    byte_ctx_t         ctx;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] mod_byte;
    logic              gen_reload;
    logic              gen_advance;

    ts_pkt_tracker #(.PKT_LEN(PKT_LEN)) u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .in_uncor (in_uncor),
        .ctx      (ctx)
    );

    assign gen_reload  = ctx.valid && (ctx.kind == KIND_INV_SYNC);
    assign gen_advance = ctx.valid && !gen_reload;

    ts_prbs_gen #(.STEPS(BYTE_W)) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .reload  (gen_reload),
        .advance (gen_advance),
        .mask    (mask)
    );

    ts_byte_mod u_mod (
        .ctx    (ctx),
        .mask   (mask),
        .bypass (bypass),
        .result (mod_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_en   <= 1'b0;
            out_sync <= 1'b0;
            out_err  <= 1'b0;
        end else begin
            out_en   <= ctx.valid;
            out_data <= ctx.valid ? mod_byte : '0;
            out_sync <= ctx.valid && (ctx.kind != KIND_DATA);
            out_err  <= ctx.valid && ctx.pkt_err;
        end
    end

endmodule

// File: rtl/ts_descrambler_chk.sv
module ts_descrambler_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sop,
    input logic [7:0] in_data,
    input logic       in_uncor,
    input logic       bypass,
    input logic [7:0] out_data,
    input logic       out_en,
    input logic       out_sync,
    input logic       out_err
);
    assert_en_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_en);

    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_en && out_data == 8'h00));

    assert_inv_sync_restored_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_data == 8'hB8 && !bypass) |=> (out_data == 8'h47));

    assert_plain_sync_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_data != 8'hB8) |=> (out_data == $past(in_data)));

    assert_bypass_sync_raw_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && bypass) |=> (out_data == $past(in_data)));

    assert_sync_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> out_sync);

    assert_sync_only_on_start_R10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_sop) |=> !out_sync);

    assert_err_with_en_R8: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_en);

    assert_err_flag_start_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_uncor) |=> out_err);

    assert_tei_forced_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_uncor) ##1 (in_valid && !in_sop) |=> out_data[7]);

endmodule

bind ts_descrambler ts_descrambler_chk u_chk (.*);

// File: tb/ts_descrambler_tb.sv
module ts_descrambler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_LEN = 188;
    localparam logic [14:0] SEED = 15'h00A9;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sop, in_uncor, bypass;
    logic [7:0] in_data;
    logic [7:0] out_data;
    logic       out_en, out_sync, out_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [14:0] m_st;
    int          m_pos;
    logic        m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_descrambler #(.PKT_LEN(PKT_LEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_uncor(in_uncor), .bypass(bypass),
        .out_data(out_data), .out_en(out_en), .out_sync(out_sync), .out_err(out_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns {next_state, mask}
    function automatic logic [22:0] gen_byte(input logic [14:0] st);
        logic [7:0] mk = 8'h00;
        logic       b;
        for (int k = 0; k < 8; k++) begin
            b  = st[14] ^ st[13];
            mk = {mk[6:0], b};
            st = {st[13:0], b};
        end
        return {st, mk};
    endfunction

    task automatic send(input logic v, input logic sop, input logic [7:0] d,
                        input logic unc, input logic byp);
        logic [7:0] e_data = 8'h00;
        logic       e_err  = 1'b0;
        logic       slot   = 1'b0;
        logic [22:0] g;
        string      tag    = "R6";
        @(negedge clk);
        in_valid = v; in_sop = sop; in_data = d; in_uncor = unc; bypass = byp;
        if (v) begin
            if (sop) m_err = unc;
            else slot = (m_pos == 1);
            if (sop && d == 8'hB8) begin
                m_st   = SEED;
                e_data = byp ? d : 8'h47;
                tag    = byp ? "R7" : "R3";
            end else begin
                g    = gen_byte(m_st);
                m_st = g[22:8];
                if (sop) begin e_data = d; tag = "R5"; end
                else begin
                    e_data = byp ? d : (d ^ g[7:0]);
                    tag    = byp ? "R7" : "R4";
                end
            end
            if (slot && m_err) begin e_data[7] = 1'b1; tag = "R9"; end
            e_err = m_err;
            if (sop) m_pos = 1;
            else if (m_pos < PKT_LEN) m_pos++;
        end
        @(posedge clk); #1;
        chk(out_en == v, "R2 out_en", out_en, v);
        chk(out_data == e_data, tag, out_data, e_data);
        chk(out_sync == (v && sop), "R10 out_sync", out_sync, v && sop);
        chk(out_err == e_err, "R8 out_err", out_err, e_err);
    endtask

    task automatic send_packet(input logic [7:0] sync_b, input logic unc,
                               input logic byp, input logic zero_first);
        logic [7:0] d;
        send(1'b1, 1'b1, sync_b, unc, byp);
        for (int i = 1; i < PKT_LEN; i++) begin
            if (($urandom % 8) == 0) send(1'b0, 1'b0, 8'($urandom), unc, byp);
            d = (zero_first && i == 1) ? 8'h00 : 8'($urandom);
            send(1'b1, 1'b0, d, unc, byp);
            if (zero_first && i == 1 && !byp)
                chk(out_data == 8'h03, "R4 first mask byte after seed", out_data, 8'h03);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        m_st = SEED; m_pos = PKT_LEN; m_err = 1'b0;
        rst = 1'b1; in_valid = 0; in_sop = 0; in_data = 0; in_uncor = 0; bypass = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_en == 0 && out_sync == 0 && out_err == 0, "R1 reset outputs",
            {out_en, out_sync, out_err}, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk(out_en == 0 && out_sync == 0 && out_err == 0, "R1 after reset",
            {out_en, out_sync, out_err}, 0);

        // group 1: directed, uncorrectable packets 2 and 5
        for (int p = 0; p < 8; p++)
            send_packet(p == 0 ? 8'hB8 : 8'h47, (p == 2 || p == 5), 1'b0, p == 0);
        // group 2: bypass on packets 0 (inverted sync) and 3-4
        for (int p = 0; p < 8; p++)
            send_packet(p == 0 ? 8'hB8 : 8'h47, p == 4, (p == 0 || p == 3 || p == 4), 1'b0);
        // group 3: random flags
        for (int p = 0; p < 8; p++)
            send_packet(p == 0 ? 8'hB8 : 8'h47, 1'($urandom), 1'($urandom), p == 0);
        // trailing idle
        send(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule